// File: doc/BRIEF.md
# OTP Program-Memory Programming Controller

This block models the parallel programming port of a small one-time-programmable program memory that also carries one configuration option byte. An external programmer raises a mode-enable pin, which here stands in for a high-voltage level. At that moment the block captures a mode code from the low address bits. It then turns chip-enable, output-enable and program strobes into read, verify and program cycles. These act either on a 4 KiB byte array or on the option byte, which sits at one fixed address.

Programming can only clear bits, because each stored byte starts erased at all-ones. The option byte drives configuration outputs continuously. One of those outputs is a ROM-lock flag that stops any further programming of the main array. All inputs are sampled on the rising clock edge and every result is registered. The strobe interface is a plain level protocol, so there is no back-pressure: a cycle is performed on every clock edge on which its strobe combination is present. A bus-drive flag stands in for the tri-state control of the data pins.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After reset, data_drive is 0, data_out is 0x00, wr_reject is 0, opt_bits reads 0xFF, rom_protect is 0, and every array byte reads 0xFF.
- R2: The mode is captured from addr[3:0] on the first clock edge at which prog_en is sampled high. Code 0 selects the array and code 3 selects the option byte. The mode then holds, whatever addr does, until prog_en is sampled low.
- R3: Any other captured code selects nothing: no data is driven, no program cycle takes effect and no reject is flagged.
- R4: In option mode only addresses whose low 12 bits equal 63 reach the option byte. At other addresses a read leaves data_drive at 0 and a program cycle changes nothing.
- R5: A read is ce_n=0, oe_n=0, pgm_n=1, with vpp_on either 0 (read) or 1 (verify). One clock after the edge it is sampled on, data_drive is 1 and data_out holds the addressed byte.
- R6: A program cycle is ce_n=0, oe_n=1, pgm_n=0, vpp_on=1. It replaces the addressed byte with the byte AND data_in, so bits can only go from 1 to 0.
- R7: A program strobe with vpp_on=0 changes nothing and raises wr_reject for exactly one cycle, one clock later.
- R8: The array decodes only addr[11:0]. An address above 0x0FFF aliases onto the byte at its low 12 bits.
- R9: With ce_n=1 or prog_en=0, data_drive stays 0 and program strobes change nothing.
- R10: Option layout: bit 0 ROM lock, bit 1 RAM lock, bit 2 RC oscillator, bit 3 auto-latch off, bit 4 permanent watchdog, bit 5 32 kHz crystal, bits 7:6 unused. A bit is active when cleared to 0. Bits 7:6 always read 1. opt_bits shows the byte continuously and reflects a write one clock after it.
- R11: rom_protect is 1 exactly while option bit 0 is 0, and once set it stays set.
- R12: While rom_protect is 1, array program cycles change nothing and raise wr_reject. Option program cycles still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (erases array and option byte) |
| prog_en | input | 1 | Mode-enable level (models the high-voltage pin) |
| vpp_on | input | 1 | Programming supply present |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| addr | input | 16 | Address; low 4 bits also carry the mode code |
| data_in | input | 8 | Program data |
| data_out | output | 8 | Read/verify data |
| data_drive | output | 1 | Data bus driven (tri-state enable) |
| opt_bits | output | 8 | Current option byte |
| rom_protect | output | 1 | Main array locked against programming |
| wr_reject | output | 1 | One-cycle pulse for a refused program attempt |

## Verification
The mode takes effect one clock after prog_en is first sampled high, so each scenario latches its mode on one edge and starts strobing on the next. Read data, data_drive and wr_reject are all registered and appear one edge after the strobes that caused them. opt_bits and rom_protect change on the same edge that writes the option byte. The bench drives inputs on the falling edge and samples outputs on the next falling edge, exactly one rising edge later. It therefore sees each result in the cycle it becomes due, and it checks the one-cycle width of the reject pulse on the falling edge after that.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_ARRAY  = 2'd1,
    MODE_OPTION = 2'd2,
    MODE_NONE   = 2'd3
  } prog_mode_e;

  localparam int unsigned CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_ARRAY  = 4'd0;
  localparam logic [CODE_W-1:0] CODE_OPTION = 4'd3;

  // option byte bit positions (a bit is active when cleared)
  localparam int unsigned OPT_ROM_LOCK  = 0;
  localparam int unsigned OPT_RAM_LOCK  = 1;
  localparam int unsigned OPT_RC_OSC    = 2;
  localparam int unsigned OPT_ALATCH    = 3;
  localparam int unsigned OPT_WDT_PERM  = 4;
  localparam int unsigned OPT_XTAL_32K  = 5;
  localparam int unsigned OPT_USED_BITS = 6;

  function automatic prog_mode_e decode_code(input logic [CODE_W-1:0] code);
    case (code)
      CODE_ARRAY:  return MODE_ARRAY;
      CODE_OPTION: return MODE_OPTION;
      default:     return MODE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/otp_mode_latch.sv
module otp_mode_latch
  import otp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic [CODE_W-1:0] code,
  output prog_mode_e        mode_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)               mode_q <= MODE_OFF;
    else if (!prog_en)        mode_q <= MODE_OFF;
    else if (mode_q == MODE_OFF) mode_q <= decode_code(code);
  end

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_OFF && prog_en) |=> $stable(mode_q));

endmodule

// File: rtl/otp_strobe_decode.sv
module otp_strobe_decode
  import otp_pkg::*;
(
  input  prog_mode_e mode,
  input  logic       prog_en,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       pgm_n,
  input  logic       vpp_on,
  input  logic       at_opt_addr,
  input  logic       protect,
  output logic       arr_rd,
  output logic       arr_wr,
  output logic       opt_rd,
  output logic       opt_wr,
  output logic       reject
);

  logic sel, rd_strobe, wr_strobe, in_arr, in_opt;

  always_comb begin
    sel       = prog_en && !ce_n;
    rd_strobe = sel && !oe_n && pgm_n;
    wr_strobe = sel && oe_n && !pgm_n;
    in_arr    = (mode == MODE_ARRAY);
    in_opt    = (mode == MODE_OPTION) && at_opt_addr;

    arr_rd = rd_strobe && in_arr;
    opt_rd = rd_strobe && in_opt;
    arr_wr = wr_strobe && in_arr && vpp_on && !protect;
    opt_wr = wr_strobe && in_opt && vpp_on;
    reject = wr_strobe && ((in_arr && (!vpp_on || protect)) || (in_opt && !vpp_on));
  end

endmodule

// File: rtl/otp_array.sv
module otp_array #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] idx,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr) begin
      mem[idx] <= mem[idx] & wdata;
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/otp_option_reg.sv
module otp_option_reg
  import otp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] opt_q
);

  localparam logic [DW-1:0] UNUSED_MASK = ~((DW'(1) << OPT_USED_BITS) - DW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)  opt_q <= '1;
    else if (wr) opt_q <= (opt_q & wdata) | UNUSED_MASK;
  end

  // R10
  opt_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((opt_q & ~$past(opt_q)) == '0));

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned ARRAY_AW = 12,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned OPT_ADDR = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic              vpp_on,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_drive,
  output logic [DATA_W-1:0] opt_bits,
  output logic              rom_protect,
  output logic              wr_reject
);

  localparam logic [ARRAY_AW-1:0] OPT_IDX = ARRAY_AW'(OPT_ADDR);

  prog_mode_e          mode;
  logic [ARRAY_AW-1:0] arr_idx;
  logic [DATA_W-1:0]   arr_rdata;
  logic                arr_rd, arr_wr, opt_rd, opt_wr, reject;

  assign arr_idx     = addr[ARRAY_AW-1:0];
  assign rom_protect = ~opt_bits[OPT_ROM_LOCK];

  otp_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en),
    .code(addr[CODE_W-1:0]), .mode_q(mode)
  );

  otp_strobe_decode u_dec (
    .mode(mode), .prog_en(prog_en), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_on(vpp_on), .at_opt_addr(arr_idx == OPT_IDX), .protect(rom_protect),
    .arr_rd(arr_rd), .arr_wr(arr_wr), .opt_rd(opt_rd), .opt_wr(opt_wr),
    .reject(reject)
  );

  otp_array #(.AW(ARRAY_AW), .DW(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .idx(arr_idx), .wr(arr_wr),
    .wdata(data_in), .rdata(arr_rdata)
  );

  otp_option_reg #(.DW(DATA_W)) u_opt (
    .clk(clk), .rst_n(rst_n), .wr(opt_wr), .wdata(data_in), .opt_q(opt_bits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_out   <= '0;
      data_drive <= 1'b0;
      wr_reject  <= 1'b0;
    end else begin
      data_drive <= arr_rd || opt_rd;
      wr_reject  <= reject;
      if (arr_rd)      data_out <= arr_rdata;
      else if (opt_rd) data_out <= opt_bits;
      else             data_out <= '0;
    end
  end

  // R9
  drive_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_drive |-> $past(!ce_n && !oe_n && prog_en));

  // R7
  reject_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> $past(!ce_n && oe_n && !pgm_n));

  // R12
  no_locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr |-> !rom_protect);

  // R11
  protect_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_protect |=> rom_protect);

  generate
    if (ADDR_W > ARRAY_AW) begin : g_alias
      // R8
      alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd && $past(arr_wr)
         && (addr[ARRAY_AW-1:0] == $past(addr[ARRAY_AW-1:0]))
         && (addr[ADDR_W-1:ARRAY_AW] != $past(addr[ADDR_W-1:ARRAY_AW])))
        |=> ((data_out & ~$past(data_in, 2)) == '0));
    end
  endgenerate

endmodule

// File: tb/tb_otp_prog_ctrl.sv
`timescale 1ns/1ps
module tb_otp_prog_ctrl;

  logic        clk = 1'b0;
  logic        rst_n, prog_en, vpp_on, ce_n, oe_n, pgm_n;
  logic [15:0] addr;
  logic [7:0]  data_in, data_out, opt_bits;
  logic        data_drive, rom_protect, wr_reject;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  otp_prog_ctrl dut (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .vpp_on(vpp_on),
    .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .addr(addr), .data_in(data_in),
    .data_out(data_out), .data_drive(data_drive), .opt_bits(opt_bits),
    .rom_protect(rom_protect), .wr_reject(wr_reject)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1; oe_n = 1; pgm_n = 1; vpp_on = 0;
  endtask

  task automatic enter_mode(input logic [3:0] code);
    prog_en = 0; idle(); step();
    addr = {12'h000, code}; prog_en = 1; step();
  endtask

  task automatic do_read(input logic [15:0] a, input logic vpp, input logic ce,
                         output logic [7:0] d, output logic drv);
    addr = a; ce_n = ce; oe_n = 0; pgm_n = 1; vpp_on = vpp;
    step();
    d = data_out; drv = data_drive;
    idle(); step();
  endtask

  task automatic do_prog(input logic [15:0] a, input logic [7:0] d, input logic vpp,
                         input logic ce, output logic rej);
    addr = a; data_in = d; ce_n = ce; oe_n = 1; pgm_n = 0; vpp_on = vpp;
    step();
    rej = wr_reject;
    idle(); step();
  endtask

  task automatic t_reset();
    logic [7:0] d; logic drv;
    check("R1 drive", {7'b0, data_drive}, 8'h00);
    check("R1 data_out", data_out, 8'h00);
    check("R1 reject", {7'b0, wr_reject}, 8'h00);
    check("R1 opt_bits", opt_bits, 8'hFF);
    check("R1 protect", {7'b0, rom_protect}, 8'h00);
    enter_mode(4'd0);
    do_read(16'h0010, 0, 0, d, drv);
    check("R1 erased byte", d, 8'hFF);
    check("R5 read drive", {7'b0, drv}, 8'h01);
  endtask

  task automatic t_program();
    logic [7:0] d; logic drv, rej;
    do_prog(16'h0010, 8'hA5, 1, 0, rej);
    check("R6 no reject", {7'b0, rej}, 8'h00);
    do_read(16'h0010, 0, 0, d, drv);
    check("R6 first program", d, 8'hA5);
    do_prog(16'h0010, 8'h3C, 1, 0, rej);
    do_read(16'h0010, 1, 0, d, drv);
    check("R6 and-merge (R5 verify)", d, 8'h24);
    check("R5 verify drive", {7'b0, drv}, 8'h01);
  endtask

  task automatic t_no_vpp();
    logic [7:0] d; logic drv, rej;
    addr = 16'h0020; data_in = 8'h00; ce_n = 0; oe_n = 1; pgm_n = 0; vpp_on = 0;
    step();
    check("R7 reject pulse", {7'b0, wr_reject}, 8'h01);
    idle(); step();
    check("R7 reject one cycle", {7'b0, wr_reject}, 8'h00);
    do_read(16'h0020, 0, 0, d, drv);
    check("R7 byte unchanged", d, 8'hFF);
    rej = 0;
  endtask

  task automatic t_alias();
    logic [7:0] d; logic drv, rej;
    do_prog(16'h1234, 8'h5A, 1, 0, rej);
    do_read(16'h0234, 0, 0, d, drv);
    check("R8 alias", d, 8'h5A);
  endtask

  task automatic t_ce_high();
    logic [7:0] d; logic drv, rej;
    do_read(16'h0010, 0, 1, d, drv);
    check("R9 ce high no drive", {7'b0, drv}, 8'h00);
    do_prog(16'h0030, 8'h00, 1, 1, rej);
    do_read(16'h0030, 0, 0, d, drv);
    check("R9 ce high no write", d, 8'hFF);
    do_prog(16'h003F, 8'h11, 1, 0, rej);
    prog_en = 0; step();
    do_read(16'h0010, 0, 0, d, drv);
    check("R9 prog_en low no drive", {7'b0, drv}, 8'h00);
  endtask

  task automatic t_option();
    logic [7:0] d; logic drv, rej;
    enter_mode(4'd3);
    do_read(16'h003F, 0, 0, d, drv);
    check("R4 option read", d, 8'hFF);
    check("R2 option mode drive", {7'b0, drv}, 8'h01);
    do_read(16'h003E, 0, 0, d, drv);
    check("R4 off-address no drive", {7'b0, drv}, 8'h00);
    do_prog(16'h003E, 8'h00, 1, 0, rej);
    check("R4 off-address no write", opt_bits, 8'hFF);
    addr = 16'h003F; data_in = 8'h3E; ce_n = 0; oe_n = 1; pgm_n = 0; vpp_on = 1;
    step();
    check("R10 opt_bits after write", opt_bits, 8'hFE);
    check("R11 protect set", {7'b0, rom_protect}, 8'h01);
    idle(); step();
    do_read(16'h003F, 0, 0, d, drv);
    check("R10 unused bits read 1", d, 8'hFE);
  endtask

  task automatic t_protect();
    logic [7:0] d; logic drv, rej;
    enter_mode(4'd0);
    do_read(16'h003F, 0, 0, d, drv);
    check("R2 array at 63", d, 8'h11);
    do_prog(16'h0040, 8'h00, 1, 0, rej);
    check("R12 locked reject", {7'b0, rej}, 8'h01);
    do_read(16'h0040, 0, 0, d, drv);
    check("R12 locked byte unchanged", d, 8'hFF);
    enter_mode(4'd3);
    do_prog(16'h003F, 8'hFB, 1, 0, rej);
    check("R12 option still writable", opt_bits, 8'hFA);
    check("R11 protect stays", {7'b0, rom_protect}, 8'h01);
  endtask

  task automatic t_bad_code();
    logic [7:0] d; logic drv, rej;
    enter_mode(4'd5);
    do_read(16'h0010, 0, 0, d, drv);
    check("R3 no drive", {7'b0, drv}, 8'h00);
    do_prog(16'h0010, 8'h00, 1, 0, rej);
    check("R3 no reject", {7'b0, rej}, 8'h00);
    enter_mode(4'd0);
    do_read(16'h0010, 0, 0, d, drv);
    check("R3 byte unchanged", d, 8'h24);
  endtask

  initial begin
    rst_n = 0; prog_en = 0; addr = '0; data_in = '0;
    idle();
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_program();
    t_no_vpp();
    t_alias();
    t_ce_high();
    t_option();
    t_protect();
    t_bad_code();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule